// File: doc/BRIEF.md
# Fully Associative Tag Directory

This block is the lookup and placement core of a small fully associative cache. It holds a fixed number of entries, each with a valid flag, a tag and one data block. Because there is no set index, the request address splits only into a tag and a byte offset, and a block may live in any entry. A lookup compares the request tag against every entry at once, in the same cycle, and returns a hit flag, the number of the matching entry, the full stored block and one word of it chosen by the offset.

When a lookup misses, the surrounding controller fetches the block from elsewhere and writes it through the fill port. The block chooses where it goes. It prefers the lowest-numbered empty entry. When every entry is occupied, it displaces the entry named by a rotating pointer. The victim it would use is always visible on an output, so the controller knows in advance which entry a fill will replace. A single-cycle flush input empties the whole directory.

Top module: `assoc_tag_dir`

## Requirements
- R1: After reset no lookup hits, and `fill_victim` is 0.
- R2: The tag is `addr[ADDR_W-1:OFFS_W]` and only the tag takes part in matching. Two addresses with equal tags but different offsets hit the same entry. Addresses whose tags differ in any bit, even the lowest one, never alias.
- R3: `hit` is 1 in the same cycle as the lookup address when some entry is valid and its stored tag equals the request tag. `hit_idx` then names that entry and `hit_block` carries its block. On a miss, `hit`, `hit_idx`, `hit_word` and `hit_block` are all 0.
- R4: `hit_word` is word number `addr[OFFS_W-1:log2(WORD_W/8)]` of the hit block. Word 0 occupies bits `[WORD_W-1:0]` of the block.
- R5: While at least one entry is invalid, a fill writes the lowest-numbered invalid entry and makes it valid. That entry can be looked up from the next cycle on.
- R6: When all entries are valid, a fill replaces the entry named by a rotating pointer. The pointer is 0 after reset and after a flush. It advances by one, wrapping from ENTRIES-1 to 0, after each fill into a full directory. `fill_victim` always shows the entry the next fill would write.
- R7: If two valid entries ever hold the same tag, a lookup of that tag reports the lower-numbered entry and its block.
- R8: `inv_all` clears every valid flag and the rotating pointer in one cycle. A fill presented in the same cycle is discarded, so neither its tag nor any other entry hits afterwards, and `fill_victim` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| inv_all | input | 1 | Flush: clear all entries this cycle |
| lkp_addr | input | ADDR_W | Lookup address |
| hit | output | 1 | Lookup matched a valid entry |
| hit_idx | output | IDX_W | Number of the matching entry (0 on miss) |
| hit_word | output | WORD_W | Word of the hit block selected by the offset (0 on miss) |
| hit_block | output | WORD_W*2^(OFFS_W-log2(WORD_W/8)) | Whole block of the matching entry (0 on miss) |
| fill_en | input | 1 | Write a new tag and block this cycle |
| fill_addr | input | ADDR_W | Address whose tag is written on a fill |
| fill_block | input | WORD_W*2^(OFFS_W-log2(WORD_W/8)) | Block written on a fill |
| fill_victim | output | IDX_W | Entry the next fill will write |

## Verification
The bench keeps the 32-bit address, the 5-bit offset and 32-bit words, so blocks are eight words and every word position can be selected. It cuts the directory to four entries. With four entries the switch from free-slot placement to rotation comes after only four fills, and a few more fills carry the rotating pointer through its wrap. The small depth also makes it cheap to build duplicate tags on purpose, and to hit a flush in the same cycle as a fill, both from a known occupancy.

// File: rtl/atd_pkg.sv
package atd_pkg;

  // How the victim for the next fill was chosen
  typedef enum logic {
    PICK_FREE   = 1'b0,
    PICK_ROTATE = 1'b1
  } pick_e;

  // Index width that never collapses to zero bits
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/atd_prio_enc.sv
module atd_prio_enc #(
  parameter int unsigned N = 8,
  parameter int unsigned W = 3
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);

  // Scan from the top down so the lowest set bit is the last one written
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end

endmodule

// File: rtl/atd_match_array.sv
module atd_match_array #(
  parameter int unsigned N     = 8,
  parameter int unsigned TAG_W = 27
) (
  input  logic [N-1:0]            valid,
  input  logic [N-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]        key,
  output logic [N-1:0]            match
);

  // One equality comparator per entry, all evaluated in parallel
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == key);
  end

endmodule

// File: rtl/atd_victim_sel.sv
module atd_victim_sel
  import atd_pkg::*;
#(
  parameter int unsigned N = 8,
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         fill,
  input  logic [N-1:0] valid,
  output logic [W-1:0] victim,
  output pick_e        pick
);

  logic         free_any;
  logic [W-1:0] free_idx;
  logic [W-1:0] rr_q, rr_d;
  logic         rr_en;

  atd_prio_enc #(.N(N), .W(W)) u_free_enc (
    .req (~valid),
    .any (free_any),
    .idx (free_idx)
  );

  always_comb begin
    pick   = free_any ? PICK_FREE : PICK_ROTATE;
    victim = (pick == PICK_FREE) ? free_idx : rr_q;
  end

  // Pointer moves only when a fill displaces a valid entry
  always_comb begin
    rr_en = 1'b0;
    rr_d  = rr_q;
    if (clear) begin
      rr_en = 1'b1;
      rr_d  = '0;
    end else if (fill && (pick == PICK_ROTATE)) begin
      rr_en = 1'b1;
      rr_d  = (rr_q == W'(N - 1)) ? '0 : rr_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rr_q <= '0;
    else if (rr_en) rr_q <= rr_d;
  end

endmodule

// File: rtl/assoc_tag_dir.sv
module assoc_tag_dir
  import atd_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned OFFS_W  = 5,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned TAG_W  = ADDR_W - OFFS_W,
  localparam int unsigned BSEL_W = $clog2(WORD_W / 8),
  localparam int unsigned WSEL_W = OFFS_W - BSEL_W,
  localparam int unsigned WORDS  = 1 << WSEL_W,
  localparam int unsigned BLK_W  = WORD_W * WORDS,
  localparam int unsigned IDX_W  = idx_bits(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_all,
  input  logic [ADDR_W-1:0] lkp_addr,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [WORD_W-1:0] hit_word,
  output logic [BLK_W-1:0]  hit_block,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [BLK_W-1:0]  fill_block,
  output logic [IDX_W-1:0]  fill_victim
);

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_n, rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  // Entry storage
  logic [ENTRIES-1:0]             valid_q, valid_d;
  logic [ENTRIES-1:0][TAG_W-1:0]  tag_q;
  logic [ENTRIES-1:0][BLK_W-1:0]  data_q;
  logic [ENTRIES-1:0]             wr_en;

  logic [TAG_W-1:0] fill_tag;
  logic             fill_go;
  pick_e            pick;

  assign fill_tag = fill_addr[ADDR_W-1:OFFS_W];
  assign fill_go  = fill_en && !inv_all;

  atd_victim_sel #(.N(ENTRIES), .W(IDX_W)) u_victim (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .clear  (inv_all),
    .fill   (fill_go),
    .valid  (valid_q),
    .victim (fill_victim),
    .pick   (pick)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign wr_en[g] = fill_go && (fill_victim == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (wr_en[g]) begin
        tag_q[g]  <= fill_tag;
        data_q[g] <= fill_block;
      end
    end
  end

  always_comb begin
    valid_d = valid_q;
    if (inv_all) valid_d = '0;
    else         valid_d = valid_q | wr_en;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) valid_q <= '0;
    else          valid_q <= valid_d;
  end

  // Lookup path
  logic [TAG_W-1:0]   lkp_tag;
  logic [WSEL_W-1:0]  lkp_wsel;
  logic [ENTRIES-1:0] match;
  logic               any_match;
  logic [IDX_W-1:0]   match_idx;
  logic [WORDS-1:0][WORD_W-1:0] blk_words;

  assign lkp_tag  = lkp_addr[ADDR_W-1:OFFS_W];
  assign lkp_wsel = lkp_addr[OFFS_W-1:BSEL_W];

  atd_match_array #(.N(ENTRIES), .TAG_W(TAG_W)) u_match (
    .valid (valid_q),
    .tags  (tag_q),
    .key   (lkp_tag),
    .match (match)
  );

  atd_prio_enc #(.N(ENTRIES), .W(IDX_W)) u_hit_enc (
    .req (match),
    .any (any_match),
    .idx (match_idx)
  );

  always_comb begin
    hit       = any_match;
    hit_idx   = any_match ? match_idx : '0;
    hit_block = any_match ? data_q[match_idx] : '0;
    blk_words = hit_block;
    hit_word  = blk_words[lkp_wsel];
  end

endmodule

// File: rtl/atd_checker.sv
module atd_checker #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned OFFS_W  = 5,
  parameter int unsigned IDX_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               inv_all,
  input logic               fill_en,
  input logic [ADDR_W-1:0]  fill_addr,
  input logic [ADDR_W-1:0]  lkp_addr,
  input logic               hit,
  input logic [IDX_W-1:0]   fill_victim,
  input logic [ENTRIES-1:0] valid_q
);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_empty_chk: assert (valid_q == '0);
    end
  end

  // R8
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_q == '0) && !hit && (fill_victim == '0));

  // R5
  fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !inv_all) |=>
      ((lkp_addr[ADDR_W-1:OFFS_W] != $past(fill_addr[ADDR_W-1:OFFS_W])) || hit));

  // R5
  free_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&valid_q) |-> !valid_q[fill_victim]);

  // R6
  rotate_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !inv_all && (&valid_q)) |=>
      (fill_victim == (($past(fill_victim) == IDX_W'(ENTRIES - 1)) ?
                        IDX_W'(0) : $past(fill_victim) + IDX_W'(1))));

  // R3
  hit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_en && !inv_all) |=> (!$stable(lkp_addr) || $stable(hit)));

endmodule

bind assoc_tag_dir atd_checker #(
  .ENTRIES (ENTRIES),
  .ADDR_W  (ADDR_W),
  .OFFS_W  (OFFS_W),
  .IDX_W   (IDX_W)
) u_atd_checker (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .inv_all     (inv_all),
  .fill_en     (fill_en),
  .fill_addr   (fill_addr),
  .lkp_addr    (lkp_addr),
  .hit         (hit),
  .fill_victim (fill_victim),
  .valid_q     (valid_q)
);

// File: tb/test_assoc_tag_dir.sv
`timescale 1ns/1ps
module test_assoc_tag_dir;

  localparam int ADDR_W  = 32;
  localparam int OFFS_W  = 5;
  localparam int WORD_W  = 32;
  localparam int ENTRIES = 4;
  localparam int TAG_W   = ADDR_W - OFFS_W;
  localparam int WORDS   = 8;
  localparam int BLK_W   = WORD_W * WORDS;
  localparam int IDX_W   = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              inv_all;
  logic [ADDR_W-1:0] lkp_addr;
  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [WORD_W-1:0] hit_word;
  logic [BLK_W-1:0]  hit_block;
  logic              fill_en;
  logic [ADDR_W-1:0] fill_addr;
  logic [BLK_W-1:0]  fill_block;
  logic [IDX_W-1:0]  fill_victim;

  always #2 clk = ~clk;

  assoc_tag_dir #(
    .ADDR_W (ADDR_W), .OFFS_W (OFFS_W), .WORD_W (WORD_W), .ENTRIES (ENTRIES)
  ) i_assoc_tag_dir (
    .clk (clk), .rst_n (rst_n), .inv_all (inv_all),
    .lkp_addr (lkp_addr), .hit (hit), .hit_idx (hit_idx),
    .hit_word (hit_word), .hit_block (hit_block),
    .fill_en (fill_en), .fill_addr (fill_addr), .fill_block (fill_block),
    .fill_victim (fill_victim)
  );

  typedef struct {
    string             req;
    logic              hit;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] word;
    logic [BLK_W-1:0]  blk;
    logic [IDX_W-1:0]  vic;
  } exp_t;

  exp_t sb_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  // Reference model of the directory contents, built from the requirements
  bit               m_valid [ENTRIES];
  logic [TAG_W-1:0] m_tag   [ENTRIES];
  logic [BLK_W-1:0] m_blk   [ENTRIES];
  int               m_rr;

  function automatic logic [ADDR_W-1:0] addr_of(input logic [TAG_W-1:0] t, input int boff);
    return {t, 5'(boff)};
  endfunction

  function automatic logic [BLK_W-1:0] mk_blk(input int seed);
    logic [BLK_W-1:0] b;
    for (int w = 0; w < WORDS; w++)
      b[w*WORD_W +: WORD_W] = {8'(seed), 8'(w), 16'hC0DE ^ 16'(seed * 7)};
    return b;
  endfunction

  function automatic int model_victim();
    for (int i = 0; i < ENTRIES; i++) if (!m_valid[i]) return i;
    return m_rr;
  endfunction

  function automatic void model_flush();
    for (int i = 0; i < ENTRIES; i++) m_valid[i] = 0;
    m_rr = 0;
  endfunction

  task automatic do_fill(input logic [ADDR_W-1:0] a, input logic [BLK_W-1:0] b, input bit with_inv);
    bit full;
    int v;
    @(negedge clk);
    fill_en    = 1'b1;
    fill_addr  = a;
    fill_block = b;
    inv_all    = with_inv;
    if (with_inv) begin
      model_flush();
    end else begin
      full = 1;
      for (int i = 0; i < ENTRIES; i++) if (!m_valid[i]) full = 0;
      v = model_victim();
      if (full) m_rr = (m_rr + 1) % ENTRIES;
      m_valid[v] = 1;
      m_tag[v]   = a[ADDR_W-1:OFFS_W];
      m_blk[v]   = b;
    end
    @(negedge clk);
    fill_en = 1'b0;
    inv_all = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    inv_all = 1'b1;
    model_flush();
    @(negedge clk);
    inv_all = 1'b0;
  endtask

  // Driver: present a lookup and push what the requirements predict
  task automatic look(input logic [ADDR_W-1:0] a, input string req);
    exp_t e;
    bit   found = 0;
    int   ws;
    @(negedge clk);
    lkp_addr = a;
    e.req = req; e.hit = 0; e.idx = '0; e.blk = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found && m_valid[i] && m_tag[i] == a[ADDR_W-1:OFFS_W]) begin
        found = 1; e.hit = 1; e.idx = IDX_W'(i); e.blk = m_blk[i];
      end
    end
    ws     = int'(a[OFFS_W-1:2]);
    e.word = e.blk[ws*WORD_W +: WORD_W];
    e.vic  = IDX_W'(model_victim());
    sb_q.push_back(e);
  endtask

  // Monitor: compare outputs shortly after each falling edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        checks++;
        if (hit !== e.hit || hit_idx !== e.idx || hit_word !== e.word ||
            hit_block !== e.blk || fill_victim !== e.vic) begin
          errors++;
          $display("FAIL %s: hit=%0b idx=%0d word=%h vic=%0d blk_ok=%0b expected hit=%0b idx=%0d word=%h vic=%0d",
                   e.req, hit, hit_idx, hit_word, fill_victim, (hit_block === e.blk),
                   e.hit, e.idx, e.word, e.vic);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  localparam logic [TAG_W-1:0] TA = 27'h0000100;
  localparam logic [TAG_W-1:0] TB = 27'h0000200;
  localparam logic [TAG_W-1:0] TC = 27'h4000300;
  localparam logic [TAG_W-1:0] TD = 27'h7FFFFFF;
  localparam logic [TAG_W-1:0] TE = 27'h0000500;
  localparam logic [TAG_W-1:0] TF = 27'h0000600;
  localparam logic [TAG_W-1:0] TG = 27'h0000700;
  localparam logic [TAG_W-1:0] TH = 27'h0000800;
  localparam logic [TAG_W-1:0] TI = 27'h0000900;
  localparam logic [TAG_W-1:0] TJ = 27'h0000A00;
  localparam logic [TAG_W-1:0] TK = 27'h0000B00;

  initial begin
    rst_n = 1'b0; inv_all = 1'b0; fill_en = 1'b0;
    lkp_addr = '0; fill_addr = '0; fill_block = '0;
    model_flush();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: empty after reset
    look(addr_of(TA, 0), "R1");

    // R5 / R3 / R4 / R2: first fill, word selection, offset independence
    do_fill(addr_of(TA, 0), mk_blk(1), 0);
    look(addr_of(TA, 0), "R3");
    look(addr_of(TA, 20), "R4");
    look(addr_of(TA, 28), "R4");
    look(addr_of(TA, 23), "R2");
    look(addr_of(TA ^ 27'h1, 0), "R2");

    do_fill(addr_of(TB, 4), mk_blk(2), 0);
    do_fill(addr_of(TC, 8), mk_blk(3), 0);
    do_fill(addr_of(TD, 31), mk_blk(4), 0);
    look(addr_of(TB, 12), "R5");
    look(addr_of(TD, 4), "R5");
    look(addr_of(TE, 0), "R3");

    // R6: rotation once full, including wrap
    do_fill(addr_of(TE, 0), mk_blk(5), 0);
    look(addr_of(TA, 0), "R6");
    look(addr_of(TE, 16), "R6");
    do_fill(addr_of(TF, 0), mk_blk(6), 0);
    look(addr_of(TF, 8), "R6");
    look(addr_of(TB, 0), "R6");
    do_fill(addr_of(TG, 0), mk_blk(7), 0);
    do_fill(addr_of(TH, 0), mk_blk(8), 0);
    do_fill(addr_of(TI, 0), mk_blk(9), 0);
    look(addr_of(TI, 24), "R6");
    look(addr_of(TH, 4), "R6");

    // R8: flush empties everything and resets the pointer
    do_flush();
    look(addr_of(TI, 0), "R8");
    look(addr_of(TF, 0), "R8");

    // R7: duplicate tag resolves to the lower entry
    do_fill(addr_of(TJ, 0), mk_blk(10), 0);
    do_fill(addr_of(TJ, 0), mk_blk(11), 0);
    look(addr_of(TJ, 12), "R7");

    // R8: flush wins over a simultaneous fill
    do_fill(addr_of(TK, 0), mk_blk(12), 1);
    look(addr_of(TK, 0), "R8");
    look(addr_of(TJ, 0), "R8");

    // R6: pointer restarts at 0 after the flush
    do_fill(addr_of(TA, 0), mk_blk(13), 0);
    do_fill(addr_of(TB, 0), mk_blk(14), 0);
    do_fill(addr_of(TC, 0), mk_blk(15), 0);
    do_fill(addr_of(TD, 0), mk_blk(16), 0);
    look(addr_of(TC, 4), "R6");
    do_fill(addr_of(TE, 0), mk_blk(17), 0);
    look(addr_of(TE, 0), "R6");

    wait (sb_q.size() == 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule